// File: doc/BRIEF.md
# Retransmit-Capable Dual-Clock FIFO

This block is a one-way queue of 36-bit words with a write port and a read port on separate clocks. Alongside normal first-in first-out use, it can replay its contents. A retransmit request moves the read position back to the first word written since the last reset. Everything written since then can be read out a second time, while new words continue to arrive behind it.

The flag style is chosen once, during reset. In standard mode, `rd_rdy` means "not empty" and a word is delivered on `rd_data` one read-clock edge after it is requested. In fall-through mode, the head word sits on `rd_data` without any request, and `rd_rdy` means "output word valid". Because the output register holds one more word, this mode stores one word beyond the memory depth. `wr_rdy` is the write-side "not full" indication in both modes.

A retransmit takes a fixed number of read-clock cycles. During that time `rd_rdy` is held low and read requests have no effect. Reading may resume once `rd_rdy` comes back high.

Top module: `rtfifo_rt`

## Requirements
- R1: While and after reset, before any write, `rd_rdy` is low and `wr_rdy` is high.
- R2: In standard mode, a read-clock edge with `rd_en` and `rd_rdy` both high puts the oldest unread word on `rd_data` after that edge. Words come out in write order, and `rd_rdy` falls once every written word has been read.
- R3: In standard mode, `wr_rdy` falls once DEPTH words are held. A write offered while `wr_rdy` is low is dropped and never appears at the read port.
- R4: In fall-through mode, the oldest word appears on `rd_data` with `rd_rdy` high and no `rd_en`. The queue accepts DEPTH+1 words before `wr_rdy` falls.
- R5: A retransmit is requested by `rt_mode` and `rt_strobe` both high at a read-clock edge, with at least one word written since reset. `rd_rdy` is low from the cycle after that edge.
- R6: When the retransmit finishes, in either mode, reading restarts at the first word written since reset and goes on in write order.
- R7: `rd_rdy` stays low for RT_CYCLES read cycles after the request and then returns high. A `rd_en` raised in that window moves nothing.
- R8: A retransmit request made when no word has been written since reset is ignored: `rd_rdy` stays low and the next word written is read normally.
- R9: If at most DEPTH-2 words have been written since reset, `wr_rdy` stays high throughout a retransmit.
- R10: Words written during a retransmit are stored behind the earlier words and are replayed after them, unaltered.
- R11: `rt_strobe` without `rt_mode` has no effect on the read position.
- R12: The flag mode is taken from `fwft_mode` at read-clock edges while `rst_n` is low. Changes to `fwft_mode` after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides, asserted asynchronously |
| fwft_mode | input | 1 | 1 selects fall-through flags, 0 selects standard flags; sampled during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| wr_rdy | output | 1 | High when a write will be accepted |
| rd_en | input | 1 | Read request (standard) or consume of the head word (fall-through) |
| rd_data | output | 36 | Delivered word |
| rd_rdy | output | 1 | Not-empty (standard) or output-valid (fall-through) |
| rt_mode | input | 1 | Retransmit enable, qualified by `rt_strobe` |
| rt_strobe | input | 1 | Retransmit request strobe |

## Verification
A read pointer that has gone astray shows at once as a wrong word on `rd_data` on the next accepted read. A retransmit that lands anywhere other than address zero shows on the first replayed word. A stuck sequencer counter shows as `rd_rdy` failing to return within a few cycles of the expected RT_CYCLES. A synchronized write count that is wrong shows as `rd_rdy` rising with nothing stored, or a stored word never becoming readable. A write-side occupancy error shows as `wr_rdy` falling one word early or late at the capacity boundary.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  localparam int RTF_DATA_W = 36;

  // Pointer arithmetic is done on 32-bit values and sliced by the caller.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words held between a leading and a trailing pointer (modulo pointer width).
  function automatic logic [31:0] fill_count(input logic [31:0] lead, input logic [31:0] trail);
    return lead - trail;
  endfunction
endpackage

// File: rtl/rtfifo_sync.sv
module rtfifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtfifo_mem.sv
module rtfifo_mem #(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rtfifo_wr_ctrl.sv
module rtfifo_wr_ctrl #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  input  logic        rewind_sync,
  output logic        wr_rdy,
  output logic        wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic [AW:0] wocc
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wptr, wptr_nxt, rptr_seen;
  logic [31:0]   gray_nxt, rbin_full, occ_full;

  assign rbin_full = rtfifo_pkg::from_gray(32'(rgray_sync));
  assign occ_full  = rtfifo_pkg::fill_count(32'(wptr), 32'(rptr_seen));
  assign wocc      = occ_full[PW-1:0];
  assign wr_rdy    = (wocc != PW'(DEPTH));
  assign wr_fire   = wr_en & wr_rdy;
  assign wptr_nxt  = wptr + PW'(wr_fire);
  assign gray_nxt  = rtfifo_pkg::to_gray(32'(wptr_nxt));
  assign waddr     = wptr[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nxt;
      wgray <= gray_nxt[PW-1:0];
    end
  end

  // The read pointer view is frozen while the read side is rewinding.
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)            rptr_seen <= '0;
    else if (!rewind_sync) rptr_seen <= rbin_full[PW-1:0];
  end
endmodule

// File: rtl/rtfifo_rd_ctrl.sv
module rtfifo_rd_ctrl #(
  parameter int AW        = 4,
  parameter int RT_CYCLES = 4
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic          rd_en,
  input  logic          rt_mode,
  input  logic          rt_strobe,
  input  logic [AW:0]   wgray_sync,
  output logic [AW:0]   rgray,
  output logic          mem_re,
  output logic [AW-1:0] raddr,
  output logic          rd_rdy,
  output logic          rt_busy,
  output logic          rt_start,
  output logic          rd_fire,
  output logic          wsync_zero,
  output logic [AW:0]   rocc,
  output logic          fwft_q
);
  localparam int PW = AW + 1;
  localparam int CW = (RT_CYCLES > 2) ? $clog2(RT_CYCLES) : 1;

  logic [PW-1:0] rptr, rptr_nxt, wbin;
  logic [31:0]   wbin_full, gray_nxt, occ_full;
  logic [CW-1:0] rt_cnt;
  logic          out_valid, empty, fetch, rt_jump;

  assign wbin_full  = rtfifo_pkg::from_gray(32'(wgray_sync));
  assign wbin       = wbin_full[PW-1:0];
  assign occ_full   = rtfifo_pkg::fill_count(32'(wbin), 32'(rptr));
  assign rocc       = occ_full[PW-1:0];
  assign empty      = (rocc == '0);
  assign wsync_zero = (wbin == '0);

  // Flag mode is captured only while reset is held.
  always_ff @(posedge rclk) begin
    if (!rst_n) fwft_q <= fwft_mode;
  end

  assign rt_start = rt_mode & rt_strobe & ~rt_busy & ~wsync_zero;
  assign rd_rdy   = ~rt_busy & (fwft_q ? out_valid : ~empty);
  assign rd_fire  = rd_en & rd_rdy & ~rt_start;
  assign fetch    = fwft_q & ~rt_busy & ~rt_start & ~empty & (~out_valid | rd_fire);
  assign mem_re   = fwft_q ? fetch : rd_fire;
  assign raddr    = rptr[AW-1:0];
  assign rt_jump  = rt_busy & (rt_cnt == CW'(1));
  assign rptr_nxt = rt_jump ? '0 : (rptr + PW'(mem_re));
  assign gray_nxt = rtfifo_pkg::to_gray(32'(rptr_nxt));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      rgray <= '0;
    end else begin
      rptr  <= rptr_nxt;
      rgray <= gray_nxt[PW-1:0];
    end
  end

  // Rewind sequencer: busy for RT_CYCLES cycles, pointer jumps one cycle before release.
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rt_busy <= 1'b0;
      rt_cnt  <= '0;
    end else if (rt_start) begin
      rt_busy <= 1'b1;
      rt_cnt  <= CW'(RT_CYCLES - 1);
    end else if (rt_busy) begin
      if (rt_cnt == '0) rt_busy <= 1'b0;
      else              rt_cnt  <= rt_cnt - CW'(1);
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (rt_start) out_valid <= 1'b0;
    else if (fetch)    out_valid <= 1'b1;
    else if (rd_fire)  out_valid <= 1'b0;
  end
endmodule

// File: rtl/rtfifo_rt.sv
module rtfifo_rt #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = rtfifo_pkg::RTF_DATA_W,
  parameter int RT_CYCLES = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_rdy,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_rdy,
  input  logic              rt_mode,
  input  logic              rt_strobe
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, wgray_sync, rgray, rgray_sync, wocc, rocc;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire, mem_re, rt_busy, rt_start, rd_fire;
  logic              wsync_zero, fwft_q, rewind_sync;

  rtfifo_wr_ctrl #(.AW(ADDR_W)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en),
    .rgray_sync(rgray_sync), .rewind_sync(rewind_sync),
    .wr_rdy(wr_rdy), .wr_fire(wr_fire), .waddr(waddr),
    .wgray(wgray), .wocc(wocc)
  );

  rtfifo_rd_ctrl #(.AW(ADDR_W), .RT_CYCLES(RT_CYCLES)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
    .rt_mode(rt_mode), .rt_strobe(rt_strobe), .wgray_sync(wgray_sync),
    .rgray(rgray), .mem_re(mem_re), .raddr(raddr), .rd_rdy(rd_rdy),
    .rt_busy(rt_busy), .rt_start(rt_start), .rd_fire(rd_fire),
    .wsync_zero(wsync_zero), .rocc(rocc), .fwft_q(fwft_q)
  );

  rtfifo_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(mem_re), .raddr(raddr), .rdata(rd_data)
  );

  rtfifo_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_sync)
  );

  rtfifo_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_sync)
  );

  rtfifo_sync #(.W(1)) u_sync_busy (
    .clk(wclk), .rst_n(rst_n), .d(rt_busy), .q(rewind_sync)
  );
endmodule

// File: rtl/rtfifo_rt_chk.sv
module rtfifo_rt_chk #(
  parameter int AW = 4,
  parameter int DW = 36
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_rdy,
  input logic [DW-1:0] rd_data,
  input logic          rt_mode,
  input logic          rt_strobe,
  input logic          rt_start,
  input logic          rt_busy,
  input logic          wsync_zero,
  input logic [AW:0]   wocc,
  input logic [AW:0]   rocc,
  input logic          fwft_q
);
  localparam int DEPTH = 1 << AW;

  assert_rewind_hides_flag_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_start |=> !rd_rdy);

  assert_rewind_holds_data_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    rt_busy |=> $stable(rd_data));

  assert_empty_rewind_ignored_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    (rt_mode && rt_strobe && wsync_zero && !rt_busy) |=> !rt_busy);

  assert_strobe_alone_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    (rt_strobe && !rt_mode && !rt_busy) |=> !rt_busy);

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    wocc <= (AW+1)'(DEPTH));

  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    rocc <= (AW+1)'(DEPTH));

  assert_mode_held_R12: assert property (@(posedge rclk) disable iff (!rst_n)
    $stable(fwft_q));
endmodule

bind rtfifo_rt rtfifo_rt_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_rdy(rd_rdy), .rd_data(rd_data),
  .rt_mode(rt_mode), .rt_strobe(rt_strobe), .rt_start(rt_start),
  .rt_busy(rt_busy), .wsync_zero(wsync_zero), .wocc(wocc), .rocc(rocc),
  .fwft_q(fwft_q)
);

// File: tb/rtfifo_rt_test.sv
module rtfifo_rt_test;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int RTC   = 4;
  localparam int DW    = 36;

  logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic          fwft_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic          rt_mode = 1'b0, rt_strobe = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_rdy, rd_rdy;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 wclk = ~wclk;  // 125 MHz write clock
  always #7 rclk = ~rclk;

  rtfifo_rt #(.ADDR_W(AW), .DATA_W(DW), .RT_CYCLES(RTC)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wr_rdy(wr_rdy),
    .rd_en(rd_en), .rd_data(rd_data), .rd_rdy(rd_rdy),
    .rt_mode(rt_mode), .rt_strobe(rt_strobe)
  );

  function automatic logic [DW-1:0] word(input int tag, input int idx);
    return {4'(tag), 32'h5A00_0000 + 32'(idx * 37)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit m);
    rst_n = 1'b0; fwft_mode = m; wr_en = 0; rd_en = 0; rt_mode = 0; rt_strobe = 0;
    repeat (3) @(negedge rclk);
    rst_n = 1'b1;
    fwft_mode = ~m;  // later changes must be ignored (R12)
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic rd_std(input logic [DW-1:0] exp, input string req);
    @(negedge rclk);
    check(rd_rdy === 1'b1, req, {35'd0, rd_rdy}, 36'd1);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    check(rd_data === exp, req, rd_data, exp);
  endtask

  task automatic rd_fwft(input logic [DW-1:0] exp, input string req);
    @(negedge rclk);
    check(rd_rdy === 1'b1, req, {35'd0, rd_rdy}, 36'd1);
    check(rd_data === exp, req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic rt_pulse(input bit m);
    @(negedge rclk); rt_mode = m; rt_strobe = 1'b1;
    @(negedge rclk); rt_mode = 1'b0; rt_strobe = 1'b0;
  endtask

  task automatic wait_rdy(input string req);
    for (int i = 0; i < 12; i++) begin
      if (rd_rdy === 1'b1) break;
      @(negedge rclk);
    end
    check(rd_rdy === 1'b1, req, {35'd0, rd_rdy}, 36'd1);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    settle(2);
    check(rd_rdy === 1'b0, "R1 rd_rdy in reset", {35'd0, rd_rdy}, 36'd0);
    do_reset(1'b0);
    check(rd_rdy === 1'b0, "R1 rd_rdy after reset", {35'd0, rd_rdy}, 36'd0);
    check(wr_rdy === 1'b1, "R1 wr_rdy after reset", {35'd0, wr_rdy}, 36'd1);
  endtask

  task automatic t_std_order;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) wr(word(1, i));
    settle(6);
    for (int i = 0; i < 3; i++) rd_std(word(1, i), "R2 order");
    settle(2);
    check(rd_rdy === 1'b0, "R2 drained", {35'd0, rd_rdy}, 36'd0);
  endtask

  task automatic t_std_full;
    do_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) wr(word(2, i));
    check(wr_rdy === 1'b0, "R3 full", {35'd0, wr_rdy}, 36'd0);
    wr(36'hD_EAD0_BEEF);
    settle(6);
    for (int i = 0; i < DEPTH; i++) rd_std(word(2, i), "R3 contents");
    settle(6);
    check(rd_rdy === 1'b0, "R3 dropped write", {35'd0, rd_rdy}, 36'd0);
  endtask

  task automatic t_fwft;
    do_reset(1'b1);
    check(rd_rdy === 1'b0, "R4 empty", {35'd0, rd_rdy}, 36'd0);
    wr(word(3, 0));
    settle(6);
    check(rd_rdy === 1'b1, "R12 mode latched", {35'd0, rd_rdy}, 36'd1);
    check(rd_data === word(3, 0), "R4 fall-through head", rd_data, word(3, 0));
    repeat (3) @(negedge wclk);
    for (int i = 1; i < DEPTH; i++) wr(word(3, i));
    check(wr_rdy === 1'b1, "R4 room for extra word", {35'd0, wr_rdy}, 36'd1);
    wr(word(3, DEPTH));
    check(wr_rdy === 1'b0, "R4 full at DEPTH+1", {35'd0, wr_rdy}, 36'd0);
    for (int i = 0; i <= DEPTH; i++) rd_fwft(word(3, i), "R4 order");
    settle(2);
    check(rd_rdy === 1'b0, "R4 drained", {35'd0, rd_rdy}, 36'd0);
  endtask

  task automatic t_rt_empty;
    do_reset(1'b0);
    rt_pulse(1'b1);
    for (int i = 0; i < 6; i++) begin
      check(rd_rdy === 1'b0, "R8 flag stays low", {35'd0, rd_rdy}, 36'd0);
      @(negedge rclk);
    end
    wr(word(4, 0));
    settle(6);
    rd_std(word(4, 0), "R8 normal read after");
  endtask

  task automatic t_rt_std;
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) wr(word(5, i));
    settle(6);
    rd_std(word(5, 0), "R2 pre-read");
    rd_std(word(5, 1), "R2 pre-read");
    rt_pulse(1'b0);
    rd_std(word(5, 2), "R11 strobe alone");
    rt_pulse(1'b1);
    check(rd_rdy === 1'b0, "R5 flag drops", {35'd0, rd_rdy}, 36'd0);
    fork
      begin
        rd_en = 1'b1;
        for (int i = 1; i < RTC; i++) begin
          @(negedge rclk);
          check(rd_rdy === 1'b0, "R7 window", {35'd0, rd_rdy}, 36'd0);
          check(wr_rdy === 1'b1, "R9 wr_rdy steady", {35'd0, wr_rdy}, 36'd1);
        end
        rd_en = 1'b0;
      end
      begin
        wr(word(5, 5));
        wr(word(5, 6));
      end
    join
    wait_rdy("R7 flag returns");
    for (int i = 0; i < 5; i++) rd_std(word(5, i), "R6 replay");
    rd_std(word(5, 5), "R10 written in window");
    rd_std(word(5, 6), "R10 written in window");
    settle(6);
    check(rd_rdy === 1'b0, "R10 nothing extra", {35'd0, rd_rdy}, 36'd0);
  endtask

  task automatic t_rt_fwft;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) wr(word(6, i));
    settle(6);
    for (int i = 0; i < 4; i++) rd_fwft(word(6, i), "R4 first pass");
    settle(2);
    check(rd_rdy === 1'b0, "R4 drained", {35'd0, rd_rdy}, 36'd0);
    rt_pulse(1'b1);
    check(rd_rdy === 1'b0, "R5 flag low in fall-through", {35'd0, rd_rdy}, 36'd0);
    wait_rdy("R7 flag returns fall-through");
    for (int i = 0; i < 4; i++) rd_fwft(word(6, i), "R6 replay fall-through");
    settle(2);
    check(rd_rdy === 1'b0, "R6 replay ends", {35'd0, rd_rdy}, 36'd0);
  endtask

  initial begin
    #(20000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_std_order();
    t_std_full();
    t_fwft();
    t_rt_empty();
    t_rt_std();
    t_rt_fwft();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule